// File: doc/BRIEF.md
# System Clock Control with Suspend Wake

This block sits between a free-running high-frequency source clock and the rest of a small controller. It provides a gated copy of the source as the system clock, and a one-cycle clock-enable pulse at the source rate divided by 8, 4, 2 or 1. A single byte-wide control register at address 0xB2 holds the run enable, the divide select and a force-suspend request. It also reports whether the source has settled.

Software writes the suspend request to stop the gated clock. The block then stays stopped until one of two wake events arrives on plain inputs: a non-idle bus resume indication, or a supply-sense level that equals a polarity chosen on a separate input. Both wake inputs pass through a synchronizer on the free-running source clock, never on the gated output. Wake detection therefore keeps working while the system clock is off. After every start, a settle counter delays the ready flag. A change of divide select waits for the end of the current divided period.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the register at 0xB2 reads 8'h80 (enabled, not yet ready, not suspended, select 00), and clk_en is low in the first cycle.
- R2: The divide select in bits 1:0 maps 00 to divide by 8, 01 to 4, 10 to 2 and 11 to 1. While running, clk_en is high for one source cycle out of every N, or on every cycle for N=1.
- R3: A new select takes effect only after the pulse that ends the current period. No period is ever shorter or longer than the ratio that was active when it began.
- R4: Writing 1 to bit 5 suspends the source: bit 5 reads 1, clk_en stays low and sys_clk does not toggle until a wake event occurs.
- R5: A bus resume pulse, even a single cycle long, ends the suspend. Bit 5 then reads 0 and the clock restarts.
- R6: The suspend also ends when supply_sense equals sense_pol. While the two differ, the suspend is held. Both polarities work.
- R7: Writing 0 to bit 5 never clears a pending suspend. The other fields of that write still apply.
- R8: Bits 4:2 always read 000, and bit 6 (ready) ignores writes.
- R9: freq_ready rises exactly 16 source cycles after the clock starts running. It falls in the same cycle that a disable or a suspend takes effect.
- R10: Clearing bit 7 stops the clock: clk_en is low, sys_clk is quiet and the divider restarts from zero. After re-enabling at divide by 8, the first pulse comes in the 8th cycle.
- R11: When a wake event is present in the cycle of a suspend write, the wake wins. The suspend is dropped, and ready and clk_en keep running.
- R12: Writes to any other address have no effect, and reads of any other address return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running high-frequency source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| bus_resume | input | 1 | Non-idle bus event indication, asynchronous |
| supply_sense | input | 1 | Supply detection level, asynchronous |
| sense_pol | input | 1 | Polarity of supply_sense that counts as a wake |
| sys_clk | output | 1 | Gated system clock |
| clk_en | output | 1 | Divided clock-enable pulse |
| freq_ready | output | 1 | Source running and settled |

## Verification
A suspend write and a wake event can land in the same cycle, and the design lets the wake win. The bench provokes this by sending a one-cycle resume pulse into the two-stage synchronizer. It times the pulse so that the synchronized wake is high only during the cycle whose closing edge carries the suspend write. The result is judged at the ports: bit 5 must read 0, freq_ready must stay high, and clk_en must keep its divide-by-4 count. A follow-up suspend write without a wake must then take hold, which shows that the drop came from the coincidence alone.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SEL_W        = 2;
  localparam int MAX_DIV_LOG2 = 3;
  localparam int CNT_W        = MAX_DIV_LOG2;

  // register bit positions
  localparam int B_EN   = 7;
  localparam int B_RDY  = 6;
  localparam int B_SUSP = 5;

  // last count value of a divided period: ratio is 2**(MAX_DIV_LOG2 - sel)
  function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    int unsigned span;
    span = 32'd1 << (MAX_DIV_LOG2 - int'(sel));
    return CNT_W'(span - 32'd1);
  endfunction

  // wake takes priority over a suspend request in the same cycle
  function automatic logic next_susp(input logic cur, input logic req, input logic wake);
    if (wake) return 1'b0;
    if (req)  return 1'b1;
    return cur;
  endfunction

  function automatic logic wake_hit(input logic resume, input logic sense, input logic pol);
    return resume | (sense ~^ pol);
  endfunction

  function automatic logic [7:0] pack_status(input logic en, input logic rdy,
                                             input logic susp, input logic [SEL_W-1:0] sel);
    logic [7:0] v;
    v            = '0;
    v[B_EN]      = en;
    v[B_RDY]     = rdy;
    v[B_SUSP]    = susp;
    v[SEL_W-1:0] = sel;
    return v;
  endfunction
endpackage

// File: rtl/sysclk_wake_sync.sv
module sysclk_wake_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs import sysclk_pkg::*; #(
  parameter logic [7:0] ADDR = 8'hB2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             wake,
  input  logic             ready,
  output logic             osc_en,
  output logic             susp,
  output logic             susp_req,
  output logic [SEL_W-1:0] divsel,
  output logic [7:0]       rdata
);
  logic hit, wr;

  assign hit      = (addr == ADDR);
  assign wr       = we & hit;
  assign susp_req = wr & wdata[B_SUSP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en <= 1'b1;
      divsel <= '0;
      susp   <= 1'b0;
    end else begin
      if (wr) begin
        osc_en <= wdata[B_EN];
        divsel <= wdata[SEL_W-1:0];
      end
      susp <= next_susp(susp, susp_req, wake);
    end
  end

  assign rdata = hit ? pack_status(osc_en, ready, susp, divsel) : 8'h00;
endmodule

// File: rtl/sysclk_settle.sv
module sysclk_settle #(
  parameter int SETTLE = 16
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int CW = $clog2(SETTLE + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run)              cnt <= '0;
    else if (cnt != CW'(SETTLE)) cnt <= cnt + CW'(1);
  end

  assign ready = run && (cnt == CW'(SETTLE));
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider import sysclk_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_act;
  logic             at_end;

  assign at_end = (cnt == div_last(sel_act));
  assign pulse  = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_act <= '0;
    end else if (!run || at_end) begin
      cnt     <= '0;
      sel_act <= sel;
    end else begin
      cnt     <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_low;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) en_low <= 1'b0;
    else        en_low <= en;

  assign gclk = clk & en_low;
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl import sysclk_pkg::*; #(
  parameter logic [7:0] REG_ADDR      = 8'hB2,
  parameter int         SETTLE_CYCLES = 16,
  parameter int         SYNC_STAGES   = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bus_resume,
  input  logic       supply_sense,
  input  logic       sense_pol,
  output logic       sys_clk,
  output logic       clk_en,
  output logic       freq_ready
);
  logic [1:0]       wake_raw, wake_sync;
  logic             wake_s, osc_en_q, susp_q, susp_req, run;
  logic [SEL_W-1:0] divsel_q;

  assign wake_raw = {supply_sense, bus_resume};

  sysclk_wake_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_raw), .q(wake_sync)
  );

  assign wake_s = wake_hit(wake_sync[0], wake_sync[1], sense_pol);

  sysclk_regs #(.ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .wake(wake_s), .ready(freq_ready), .osc_en(osc_en_q), .susp(susp_q),
    .susp_req(susp_req), .divsel(divsel_q), .rdata(reg_rdata)
  );

  assign run = osc_en_q & ~susp_q;

  sysclk_settle #(.SETTLE(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(run), .ready(freq_ready)
  );

  sysclk_divider u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(divsel_q), .pulse(clk_en)
  );

  sysclk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(run), .gclk(sys_clk)
  );
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk import sysclk_pkg::*; #(
  parameter int         SETTLE_CYCLES = 16,
  parameter logic [7:0] REG_ADDR      = 8'hB2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             susp_q,
  input logic             susp_req,
  input logic             wake_s,
  input logic [SEL_W-1:0] divsel_q,
  input logic             clk_en,
  input logic             freq_ready,
  input logic [7:0]       reg_rdata,
  input logic [7:0]       reg_addr
);
  logic [7:0]       age, gap, span;
  logic [SEL_W-1:0] sel_cap;

  assign span = (8'd1 << MAX_DIV_LOG2) >> sel_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; gap <= '0; sel_cap <= '0;
    end else begin
      if (!run)               age <= '0;
      else if (age != 8'hFF)  age <= age + 8'd1;
      if (!run || clk_en) begin
        gap <= '0; sel_cap <= divsel_q;
      end else begin
        gap <= gap + 8'd1;
      end
    end
  end

  assert_no_runt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (gap == span - 8'd1));
  assert_stopped_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !clk_en);
  assert_suspend_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && !wake_s) |=> susp_q);
  assert_susp_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_ADDR) |-> (reg_rdata[B_SUSP] == susp_q));
  assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_s |=> !susp_q);
  assert_susp_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && !wake_s) |=> susp_q);
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4:2] == 3'b000);
  assert_ready_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_ready |-> run);
  assert_ready_age_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_ready) |-> (age == 8'(SETTLE_CYCLES)));
  assert_wake_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_s && susp_req && run) |=> run);
  assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != REG_ADDR) |-> (reg_rdata == 8'h00));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .susp_q(susp_q), .susp_req(susp_req),
  .wake_s(wake_s), .divsel_q(divsel_q), .clk_en(clk_en), .freq_ready(freq_ready),
  .reg_rdata(reg_rdata), .reg_addr(reg_addr)
);

// File: tb/sim_sysclk_ctrl.sv
module sim_sysclk_ctrl;
  localparam logic [7:0] A = 8'hB2;

  logic       clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = A, reg_wdata = 8'h00, reg_rdata;
  logic       bus_resume = 1'b0, supply_sense = 1'b0, sense_pol = 1'b1;
  logic       sys_clk, clk_en, freq_ready;
  int         checks = 0, fails = 0, gclk_edges = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge sys_clk) gclk_edges++;

  sysclk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_resume(bus_resume),
    .supply_sense(supply_sense), .sense_pol(sense_pol), .sys_clk(sys_clk),
    .clk_en(clk_en), .freq_ready(freq_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = A;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    reg_addr = a; #1; v = reg_rdata; reg_addr = A; #1;
    check(v == exp, req, int'(v), int'(exp));
  endtask

  task automatic window(input int n, output int en_cnt, output int g_cnt);
    int e;
    e = 0; gclk_edges = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en) e++;
    end
    en_cnt = e; g_cnt = gclk_edges;
  endtask

  function automatic int ratio(input int sel);
    return 8 / (1 << sel);
  endfunction

  initial begin
    int e, g, gap, first_en, first_rdy;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd_check(A, 8'h80, "R1");
    check(clk_en == 1'b0, "R1", clk_en, 0);
    step(20);
    rd_check(A, 8'hC0, "R9");

    // R2 sweep of the divide select
    for (int s = 0; s < 4; s++) begin
      wr(A, 8'h80 | 8'(s));
      step(20);
      rd_check(A, 8'hC0 | 8'(s), "R2");
      window(64, e, g);
      check(e == 64 / ratio(s), "R2", e, 64 / ratio(s));
      check(g == 64, "R2", g, 64);
    end

    // R8 unused bits and ready bit ignore writes
    wr(A, 8'hDC);
    rd_check(A, 8'hC0, "R8");

    // R3 select change waits for the period boundary
    step(20);
    while (!clk_en) @(negedge clk);
    reg_addr = A; reg_wdata = 8'h83; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    gap = 1;
    while (!clk_en && gap < 20) begin
      @(negedge clk);
      gap++;
    end
    check(gap == 8, "R3", gap, 8);
    step(1);
    check(clk_en == 1'b1, "R3", clk_en, 1);

    // R12 other address ignored and reads zero
    wr(8'hB3, 8'hA0);
    rd_check(A, 8'hC3, "R12");
    rd_check(8'hB3, 8'h00, "R12");
    window(16, e, g);
    check(e == 16, "R12", e, 16);

    // R10 disable
    wr(A, 8'h00);
    check(freq_ready == 1'b0, "R9", freq_ready, 0);
    rd_check(A, 8'h00, "R10");
    window(32, e, g);
    check(e == 0, "R10", e, 0);
    check(g == 0, "R10", g, 0);
    wr(A, 8'h40);
    rd_check(A, 8'h00, "R8");
    wr(A, 8'h80);
    first_en = -1; first_rdy = -1;
    for (int k = 0; k < 40; k++) begin
      if (clk_en && first_en < 0) first_en = k;
      if (freq_ready && first_rdy < 0) first_rdy = k;
      @(negedge clk);
    end
    check(first_en == 7, "R10", first_en, 7);
    check(first_rdy == 16, "R9", first_rdy, 16);

    // R4 suspend, sense does not match (pol 1, sense 0)
    wr(A, 8'hA0);
    check(freq_ready == 1'b0, "R9", freq_ready, 0);
    check(clk_en == 1'b0, "R4", clk_en, 0);
    rd_check(A, 8'hA0, "R4");
    window(40, e, g);
    check(e == 0, "R4", e, 0);
    check(g == 0, "R4", g, 0);
    rd_check(A, 8'hA0, "R6");

    // R7 writing 0 to the suspend bit keeps the suspend
    wr(A, 8'h81);
    rd_check(A, 8'hA1, "R7");
    window(16, e, g);
    check(e == 0, "R7", e, 0);

    // R6 sense matches polarity 1
    supply_sense = 1'b1;
    step(5);
    rd_check(A, 8'h81, "R6");
    step(20);
    rd_check(A, 8'hC1, "R6");
    window(64, e, g);
    check(e == 16, "R2", e, 16);

    // R6 polarity 0
    sense_pol = 1'b0;
    step(3);
    wr(A, 8'hA1);
    step(10);
    rd_check(A, 8'hA1, "R6");
    supply_sense = 1'b0;
    step(5);
    rd_check(A, 8'h81, "R6");
    step(20);

    // R5 single-cycle bus resume
    supply_sense = 1'b1;
    step(4);
    wr(A, 8'hA1);
    step(5);
    rd_check(A, 8'hA1, "R5");
    bus_resume = 1'b1;
    step(1);
    bus_resume = 1'b0;
    step(5);
    rd_check(A, 8'h81, "R5");
    step(20);
    rd_check(A, 8'hC1, "R5");

    // R11 wake in the same cycle as a suspend write
    bus_resume = 1'b1;
    @(negedge clk);
    bus_resume = 1'b0;
    @(negedge clk);
    reg_addr = A; reg_wdata = 8'hA1; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd_check(A, 8'hC1, "R11");
    check(freq_ready == 1'b1, "R11", freq_ready, 1);
    window(32, e, g);
    check(e == 8, "R11", e, 8);
    wr(A, 8'hA1);
    rd_check(A, 8'hA1, "R4");
    bus_resume = 1'b1;
    step(1);
    bus_resume = 1'b0;
    step(25);
    rd_check(A, 8'hC1, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule